// File: doc/BRIEF.md
# Receive Polarity Corrector

This block decides whether the receive pair of a twisted-pair port is wired with its conductors swapped, and drives a single invert control for the receive data path. Upstream slicing logic hands it qualified single-cycle strobes: one for each accepted link pulse, tagged with that pulse's polarity, and one at the end of each received frame, tagged with whether the end delimiter was well formed and which polarity it showed. The block also sees the link state (fail or pass), a frame-in-progress level, and a strap that turns the function off.

While the link is failed, the block tracks the run of identical-polarity link pulses. When the link goes to pass and the run is long enough, the run's polarity becomes the provisional setting. Frame end delimiters then take over. The first valid delimiter sets the polarity outright. A later valid delimiter that agrees locks the setting, and one that disagrees replaces it. Once the setting is locked it holds until the link fails again or reset is applied. The invert control follows the decision only between frames. The status output is low for normal polarity and high while inversion is applied.

All inputs are plain levels or strobes with no back-pressure. A strobe is taken in the cycle it is high, and the upstream side needs no handshake.

Top module: `rxpol_corrector`

## Requirements
- R1: After reset `rx_invert` is 0 and `pol_ok_n` is 0.
- R2: When `link_pass` goes from 0 to 1 and the last `RUN_LEN` (default 5) link pulses seen while `link_pass` was 0 all had the same polarity (`lp_neg`=1 means negative, i.e. reversed), that polarity becomes the decision: negative gives `rx_invert`=1, positive gives 0.
- R3: A link pulse whose polarity differs from the one before it restarts the run, so a shorter run at link-pass entry leaves the decision unchanged.
- R4: While `link_pass` is 1, link pulse strobes do not change the decision.
- R5: The first valid end delimiter (`eop_stb`=1, `eop_valid`=1) after arming sets the decision to `eop_neg`, whatever the decision was before.
- R6: A later valid delimiter whose polarity equals the current decision locks it. While the block is locked and the link stays in pass, no strobe changes the decision.
- R7: A later valid delimiter that disagrees with the decision before lock replaces the decision, and the block stays armed.
- R8: A delimiter with `eop_valid`=0 changes nothing.
- R9: `link_pass`=0 clears lock and re-arms the block. Delimiters are ignored while `link_pass` is 0.
- R10: `pol_ok_n` is 1 exactly when `rx_invert` is 1.
- R11: While `pol_dis` is 1, `rx_invert` is 0 from the next cycle on, and all strobes are ignored. Releasing the strap leaves the block re-armed with a non-inverted decision.
- R12: `rx_invert` only takes a new value on a clock edge at which `rx_busy` was 0. A decision made during a frame is applied after the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_dis | input | 1 | Strap that disables detection and forces non-inverted |
| link_pass | input | 1 | Link state: 1 = pass, 0 = fail |
| lp_stb | input | 1 | One-cycle strobe for a qualified link pulse |
| lp_neg | input | 1 | Polarity of the strobed link pulse, 1 = negative |
| eop_stb | input | 1 | One-cycle strobe at the end of a received frame |
| eop_valid | input | 1 | End delimiter of the strobed frame was well formed |
| eop_neg | input | 1 | Polarity of the strobed end delimiter, 1 = reversed |
| rx_busy | input | 1 | A receive frame is in progress |
| rx_invert | output | 1 | Invert control for the receive data path |
| pol_ok_n | output | 1 | Status: 0 = normal polarity, 1 = inverted |

## Verification
The link-pulse path is tried with a clean run of positive pulses, a clean run of negative pulses and a broken run, which separates full-run detection from counting that fails to restart. The delimiter path is tried with invalid, first-valid, disagreeing, agreeing and post-lock delimiters, which separates arming, replacement and lock-in. A delimiter that lands while a frame is still in progress separates deferred application from immediate application. Strap assertion in the middle of traffic, followed by release, shows that the strap forces the output and clears the decision.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PROV  = 2'd1,
    ST_LOCK  = 2'd2
  } pol_state_e;
endpackage

// File: rtl/lp_run_tracker.sv
module lp_run_tracker #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pulse_stb,
  input  logic pulse_neg,
  output logic run_full,
  output logic run_neg
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_cnt;
  logic             last_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      last_neg <= 1'b0;
    end else if (clr) begin
      run_cnt  <= '0;
      last_neg <= 1'b0;
    end else if (pulse_stb) begin
      last_neg <= pulse_neg;
      if (run_cnt != '0 && pulse_neg == last_neg) begin
        if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= CNT_W'(1);
      end
    end
  end

  assign run_full = (run_cnt == CNT_MAX);
  assign run_neg  = last_neg;
endmodule

// File: rtl/pol_decider.sv
module pol_decider
  import rxpol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dis,
  input  logic       link_pass,
  input  logic       eop_stb,
  input  logic       eop_valid,
  input  logic       eop_neg,
  input  logic       run_full,
  input  logic       run_neg,
  output logic       target,
  output logic       locked,
  output logic       link_q
);
  pol_state_e state_q, state_d;
  logic       target_d;
  logic       entering;
  logic       good_eop;

  assign entering = link_pass && !link_q;
  assign good_eop = eop_stb && eop_valid;

  always_comb begin
    state_d  = state_q;
    target_d = target;
    if (dis) begin
      state_d  = ST_ARMED;
      target_d = 1'b0;
    end else if (!link_pass) begin
      state_d = ST_ARMED;
    end else if (good_eop) begin
      unique case (state_q)
        ST_ARMED: begin
          target_d = eop_neg;
          state_d  = ST_PROV;
        end
        ST_PROV: begin
          if (eop_neg == target) state_d = ST_LOCK;
          else                   target_d = eop_neg;
        end
        default: ;
      endcase
    end else if (entering && run_full && state_q == ST_ARMED) begin
      target_d = run_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      target  <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      target  <= target_d;
      link_q  <= link_pass;
    end
  end

  assign locked = (state_q == ST_LOCK);
endmodule

// File: rtl/invert_gate.sv
module invert_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic frame_active,
  input  logic target,
  output logic invert
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             invert <= 1'b0;
    else if (dis)           invert <= 1'b0;
    else if (!frame_active) invert <= target;
  end
endmodule

// File: rtl/rxpol_corrector.sv
module rxpol_corrector #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_dis,
  input  logic link_pass,
  input  logic lp_stb,
  input  logic lp_neg,
  input  logic eop_stb,
  input  logic eop_valid,
  input  logic eop_neg,
  input  logic rx_busy,
  output logic rx_invert,
  output logic pol_ok_n
);
  logic run_full, run_neg;
  logic target, locked, link_q;
  logic run_clr;

  assign run_clr = pol_dis || link_pass;

  lp_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_clr),
    .pulse_stb (lp_stb),
    .pulse_neg (lp_neg),
    .run_full  (run_full),
    .run_neg   (run_neg)
  );

  pol_decider u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .dis       (pol_dis),
    .link_pass (link_pass),
    .eop_stb   (eop_stb),
    .eop_valid (eop_valid),
    .eop_neg   (eop_neg),
    .run_full  (run_full),
    .run_neg   (run_neg),
    .target    (target),
    .locked    (locked),
    .link_q    (link_q)
  );

  invert_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .dis          (pol_dis),
    .frame_active (rx_busy),
    .target       (target),
    .invert       (rx_invert)
  );

  assign pol_ok_n = rx_invert;
endmodule

// File: rtl/rxpol_corrector_chk.sv
module rxpol_corrector_chk (
  input logic clk,
  input logic rst_n,
  input logic pol_dis,
  input logic link_pass,
  input logic eop_stb,
  input logic eop_valid,
  input logic eop_neg,
  input logic rx_busy,
  input logic rx_invert,
  input logic target,
  input logic locked,
  input logic link_q
);
  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_busy) && !$past(pol_dis)) |-> $stable(rx_invert));

  // R11
  strap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pol_dis) |-> !rx_invert);

  // R9
  fail_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_pass |=> !locked);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && link_pass && !pol_dis) |=> $stable(target));

  // R8
  bad_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_stb && !eop_valid && link_pass && link_q && !pol_dis)
      |=> ($stable(target) && $stable(locked)));

  // R5
  first_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_stb && eop_valid && link_pass && !locked && !pol_dis)
      |=> (target == $past(eop_neg)));
endmodule

bind rxpol_corrector rxpol_corrector_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pol_dis   (pol_dis),
  .link_pass (link_pass),
  .eop_stb   (eop_stb),
  .eop_valid (eop_valid),
  .eop_neg   (eop_neg),
  .rx_busy   (rx_busy),
  .rx_invert (rx_invert),
  .target    (target),
  .locked    (locked),
  .link_q    (link_q)
);

// File: tb/test_rxpol_corrector.sv
`timescale 1ns/1ps
module test_rxpol_corrector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_dis = 1'b0, link_pass = 1'b0, lp_stb = 1'b0, lp_neg = 1'b0;
  logic eop_stb = 1'b0, eop_valid = 1'b0, eop_neg = 1'b0, rx_busy = 1'b0;
  logic rx_invert, pol_ok_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rxpol_corrector i_rxpol_corrector (
    .clk(clk), .rst_n(rst_n), .pol_dis(pol_dis), .link_pass(link_pass),
    .lp_stb(lp_stb), .lp_neg(lp_neg), .eop_stb(eop_stb),
    .eop_valid(eop_valid), .eop_neg(eop_neg), .rx_busy(rx_busy),
    .rx_invert(rx_invert), .pol_ok_n(pol_ok_n)
  );

  // Behavioural reference: state 0 armed, 1 provisional, 2 locked
  int m_inv = 0, m_tgt = 0, m_st = 0, m_last = 0, m_lq = 0;
  int run_q[$];

  function automatic bit run_full_m();
    if (run_q.size() < 5) return 1'b0;
    for (int i = 1; i < 5; i++)
      if (run_q[run_q.size()-1-i] != run_q[run_q.size()-1]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_inv = 0; m_tgt = 0; m_st = 0; m_lq = 0; run_q.delete();
    end else begin
      int old_tgt;
      old_tgt = m_tgt;
      if (pol_dis) begin
        m_inv = 0; m_tgt = 0; m_st = 0; run_q.delete();
      end else begin
        if (!rx_busy) m_inv = old_tgt;
        if (!link_pass) begin
          m_st = 0;
          if (lp_stb) begin
            if (run_q.size() > 0 && run_q[run_q.size()-1] != int'(lp_neg))
              run_q.delete();
            run_q.push_back(int'(lp_neg));
          end
        end else begin
          if (eop_stb && eop_valid) begin
            if (m_st == 0) begin m_tgt = int'(eop_neg); m_st = 1; end
            else if (m_st == 1) begin
              if (int'(eop_neg) == m_tgt) m_st = 2; else m_tgt = int'(eop_neg);
            end
          end else if (m_lq == 0 && m_st == 0 && run_full_m()) begin
            m_tgt = run_q[run_q.size()-1];
          end
          run_q.delete();
        end
      end
      m_lq = int'(link_pass);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(rx_invert) != m_inv || pol_ok_n != rx_invert) begin
        errors++;
        $display("FAIL %s model: rx_invert=%0d pol_ok_n=%0d expected %0d",
                 cur_req, rx_invert, pol_ok_n, m_inv);
      end
    end
  end

  task automatic expect_inv(input string req, input logic exp);
    @(negedge clk);
    checks++;
    if (rx_invert !== exp || pol_ok_n !== exp) begin
      errors++;
      $display("FAIL %s: rx_invert=%0b pol_ok_n=%0b expected %0b", req,
               rx_invert, pol_ok_n, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(input logic neg);
    lp_stb = 1'b1; lp_neg = neg; step(1);
    lp_stb = 1'b0; step(1);
  endtask

  task automatic frame(input logic valid, input logic neg, input logic stay_busy);
    rx_busy = 1'b1; step(3);
    rx_busy = stay_busy;
    eop_stb = 1'b1; eop_valid = valid; eop_neg = neg; step(1);
    eop_stb = 1'b0; eop_valid = 1'b0;
    if (!stay_busy) step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    cur_req = "R1";  expect_inv("R1", 1'b0);

    cur_req = "R2";
    repeat (5) pulse(1'b1);
    link_pass = 1'b1; step(3);
    expect_inv("R2", 1'b1);
    expect_inv("R10", 1'b1);

    cur_req = "R9";
    link_pass = 1'b0; step(2);
    repeat (5) pulse(1'b0);
    link_pass = 1'b1; step(3);
    expect_inv("R9", 1'b0);

    cur_req = "R3";
    link_pass = 1'b0; step(2);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    repeat (4) pulse(1'b1);
    link_pass = 1'b1; step(3);
    expect_inv("R3", 1'b0);

    cur_req = "R4";
    repeat (5) pulse(1'b1);
    step(2);
    expect_inv("R4", 1'b0);

    cur_req = "R8";
    frame(1'b0, 1'b1, 1'b0);
    expect_inv("R8", 1'b0);

    cur_req = "R5";
    frame(1'b1, 1'b1, 1'b0);
    expect_inv("R5", 1'b1);

    cur_req = "R7";
    frame(1'b1, 1'b0, 1'b0);
    expect_inv("R7", 1'b0);

    cur_req = "R6";
    frame(1'b1, 1'b0, 1'b0);
    expect_inv("R6", 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    expect_inv("R6", 1'b0);
    repeat (5) pulse(1'b1);
    expect_inv("R6", 1'b0);

    cur_req = "R12";
    link_pass = 1'b0; step(2);
    link_pass = 1'b1; step(2);
    frame(1'b1, 1'b1, 1'b1);
    step(2);
    expect_inv("R12", 1'b0);
    rx_busy = 1'b0; step(2);
    expect_inv("R12", 1'b1);

    cur_req = "R11";
    pol_dis = 1'b1; step(1);
    expect_inv("R11", 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    expect_inv("R11", 1'b0);
    pol_dis = 1'b0; step(3);
    expect_inv("R11", 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    expect_inv("R11", 1'b1);

    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule